// File: doc/BRIEF.md
# Four-Way Recency-Order Replacement Tracker

This block tracks how recently each of the four ways of every cache set was used, and names the way that should be replaced next. Each cycle it accepts one request: a set index and an operation code. The operation is either a hit on a given way, a miss that fills the replacement victim, or an invalidation of a given way. A request with no operation is also allowed. Tag matching, line storage, write-back of dirty lines and the memory side belong to the surrounding cache and are not part of this block.

Each set keeps its recency order as four 2-bit way numbers, ranked from most recent to least recent. A hit or a fill moves a way to the front. Every way that was more recent than it moves back one rank, and every way behind its old rank stays where it is. An invalidation sends a way to the back, and every way that was behind it moves forward one rank. The victim is always the way at the back, so an invalidated way is the first one refilled. The addressed set's order and victim are shown combinationally, and an update is written on the next clock edge.

Top module: `lru_tracker`

## Requirements
- R1: After a synchronous active-high reset every set holds the order 0,1,2,3 (way 0 most recent, way 3 least recent), so the victim of every set is way 3.
- R2: The order of every set always contains each of the way numbers 0 to 3 exactly once.
- R3: A hit (op code 1) on way w writes w into the most recent rank. The ways that were more recent than w move back one rank, and the ranks behind w's old rank keep their values. For example, order 1,0,2,3 with a hit on way 2 becomes 2,1,0,3.
- R4: A hit on the way already at the most recent rank leaves the order unchanged.
- R5: A fill (op code 2) takes the way at the least recent rank, moves it to the most recent rank, and moves the other three back one rank each. The way input is ignored on a fill.
- R6: An invalidation (op code 3) of way w writes w into the least recent rank, and every way that was behind w moves forward one rank. For example, order 1,0,2,3 with an invalidation of way 0 becomes 1,2,3,0.
- R7: Invalidating the way already at the least recent rank leaves the order unchanged.
- R8: victim_o is always the least recent way of the set selected by set_i, and it follows a change of set_i in the same cycle. order_o shows that set's order with the most recent way in bits 1:0, the next in bits 3:2, then bits 5:4, and the least recent in bits 7:6. An update becomes visible after the next rising clock edge.
- R9: An operation changes only the addressed set. All other sets keep their order.
- R10: Op code 0 (idle) changes no set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Operation: 0 idle, 1 hit, 2 fill, 3 invalidate |
| set_i | input | SET_IDX_W | Set index for the operation and for the read-out |
| way_i | input | 2 | Way for a hit or an invalidation |
| victim_o | output | 2 | Least recent way of the addressed set |
| order_o | output | 8 | Recency order of the addressed set, most recent in bits 1:0 |

## Verification
The hardest cases to reach are the rank-dependent shifts. For a hit or an invalidation, how far the entries move depends on where the target way sits in the order. That position can only be set up through a chain of earlier hits, fills and invalidations on the same set. The stimulus table therefore drives one set through a planned sequence, so that the target way lands in each of the four ranks in turn: front, back and both middle ranks. Interleaved operations on other sets confirm that those sets' orders are not disturbed.

// File: rtl/lru_pkg.sv
package lru_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;
    localparam int ORD_W = WAYS * WAY_W;

    typedef logic [WAY_W-1:0] way_t;
    // element 0 is the most recent rank, element WAYS-1 the least recent
    typedef way_t [WAYS-1:0] order_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_HIT   = 2'd1,
        OP_FILL  = 2'd2,
        OP_INVAL = 2'd3
    } op_e;

    localparam order_t RESET_ORDER = {2'd3, 2'd2, 2'd1, 2'd0};

    function automatic int unsigned rank_of(order_t o, way_t w);
        int unsigned r;
        r = 0;
        for (int i = 0; i < WAYS; i++) begin
            if (o[i] == w) r = i;
        end
        return r;
    endfunction

    // move w to the front; entries ahead of its old rank slide back
    function automatic order_t promote(order_t o, way_t w);
        order_t      n;
        int unsigned p;
        p    = rank_of(o, w);
        n[0] = w;
        for (int i = 1; i < WAYS; i++) begin
            n[i] = (i <= p) ? o[i-1] : o[i];
        end
        return n;
    endfunction

    // move w to the back; entries behind its old rank slide forward
    function automatic order_t demote(order_t o, way_t w);
        order_t      n;
        int unsigned p;
        p         = rank_of(o, w);
        n[WAYS-1] = w;
        for (int i = 0; i < WAYS - 1; i++) begin
            n[i] = (i >= p) ? o[i+1] : o[i];
        end
        return n;
    endfunction

endpackage

// File: rtl/lru_order_store.sv
module lru_order_store
    import lru_pkg::*;
#(
    parameter int SET_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SET_IDX_W-1:0] rd_idx,
    input  logic                 wr_en,
    input  logic [SET_IDX_W-1:0] wr_idx,
    input  order_t               wr_order,
    output order_t               rd_order
);
    localparam int SETS = 1 << SET_IDX_W;

    order_t table_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                table_q[s] <= RESET_ORDER;
            end
        end else if (wr_en) begin
            table_q[wr_idx] <= wr_order;
        end
    end

    assign rd_order = table_q[rd_idx];

endmodule

// File: rtl/lru_order_update.sv
module lru_order_update
    import lru_pkg::*;
(
    input  op_e    op,
    input  way_t   way,
    input  order_t cur,
    output order_t nxt,
    output logic   wr_en
);
    always_comb begin
        nxt   = cur;
        wr_en = 1'b0;
        unique case (op)
            OP_HIT: begin
                nxt   = promote(cur, way);
                wr_en = 1'b1;
            end
            OP_FILL: begin
                nxt   = promote(cur, cur[WAYS-1]);
                wr_en = 1'b1;
            end
            OP_INVAL: begin
                nxt   = demote(cur, way);
                wr_en = 1'b1;
            end
            default: begin
                nxt   = cur;
                wr_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lru_tracker.sv
module lru_tracker
    import lru_pkg::*;
#(
    parameter int SET_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           op_i,
    input  logic [SET_IDX_W-1:0] set_i,
    input  logic [1:0]           way_i,
    output logic [1:0]           victim_o,
    output logic [7:0]           order_o
);
    order_t cur_order;
    order_t nxt_order;
    logic   upd_en;

    lru_order_store #(.SET_IDX_W(SET_IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (set_i),
        .wr_en    (upd_en),
        .wr_idx   (set_i),
        .wr_order (nxt_order),
        .rd_order (cur_order)
    );

    lru_order_update u_update (
        .op    (op_e'(op_i)),
        .way   (way_t'(way_i)),
        .cur   (cur_order),
        .nxt   (nxt_order),
        .wr_en (upd_en)
    );

    assign order_o  = cur_order;
    assign victim_o = cur_order[WAYS-1];

endmodule

// File: rtl/lru_tracker_chk.sv
module lru_tracker_chk #(
    parameter int SET_IDX_W = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           op_i,
    input logic [SET_IDX_W-1:0] set_i,
    input logic [1:0]           way_i,
    input logic [1:0]           victim_o,
    input logic [7:0]           order_o
);
    logic [3:0] present;
    always_comb begin
        present = 4'b0;
        for (int i = 0; i < 4; i++) present[order_o[2*i +: 2]] = 1'b1;
    end

    // R1: fresh out of reset the addressed set holds 0,1,2,3
    p_reset_order_r1: assert property (@(posedge clk)
        $fell(rst) |-> order_o == 8'hE4);

    // R2: always a permutation of the four ways
    p_perm_r2: assert property (@(posedge clk) disable iff (rst)
        present == 4'hF);

    // R3: a hit lands the way at the front of the same set
    p_hit_front_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd1) |=> (set_i != $past(set_i)) || (order_o[1:0] == $past(way_i)));

    // R5: a fill brings the former victim to the front
    p_fill_front_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd2) |=> (set_i != $past(set_i)) || (order_o[1:0] == $past(victim_o)));

    // R6: an invalidated way becomes the victim of the same set
    p_inval_back_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd3) |=> (set_i != $past(set_i)) || (victim_o == $past(way_i)));

    // R10: idle leaves the addressed order untouched
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd0) |=> (set_i != $past(set_i)) || $stable(order_o));

endmodule

bind lru_tracker lru_tracker_chk #(.SET_IDX_W(SET_IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .set_i    (set_i),
    .way_i    (way_i),
    .victim_o (victim_o),
    .order_o  (order_o)
);

// File: tb/lru_tracker_tb.sv
module lru_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 4;
    localparam int NVEC       = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       op_i = 2'd0;
    logic [IDX_W-1:0] set_i = '0;
    logic [1:0]       way_i = 2'd0;
    logic [1:0]       victim_o;
    logic [7:0]       order_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lru_tracker #(.SET_IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .set_i(set_i),
        .way_i(way_i), .victim_o(victim_o), .order_o(order_o)
    );

    // row: {req[3:0], op[1:0], set[3:0], way[1:0], a, b, c, d} with a most recent
    localparam logic [21:0] VEC [NVEC] = '{
        {4'd3,  2'd1, 4'd5,  2'd1, 2'd1, 2'd0, 2'd2, 2'd3}, // R3 hit rank 1
        {4'd3,  2'd1, 4'd5,  2'd2, 2'd2, 2'd1, 2'd0, 2'd3}, // R3 hit rank 2
        {4'd4,  2'd1, 4'd5,  2'd2, 2'd2, 2'd1, 2'd0, 2'd3}, // R4 hit on front
        {4'd5,  2'd2, 4'd5,  2'd0, 2'd3, 2'd2, 2'd1, 2'd0}, // R5 fill, way ignored
        {4'd6,  2'd3, 4'd5,  2'd2, 2'd3, 2'd1, 2'd0, 2'd2}, // R6 inval rank 1
        {4'd5,  2'd2, 4'd5,  2'd3, 2'd2, 2'd3, 2'd1, 2'd0}, // R5 fill victim 2
        {4'd7,  2'd3, 4'd5,  2'd0, 2'd2, 2'd3, 2'd1, 2'd0}, // R7 inval on back
        {4'd10, 2'd0, 4'd5,  2'd1, 2'd2, 2'd3, 2'd1, 2'd0}, // R10 idle
        {4'd6,  2'd3, 4'd5,  2'd2, 2'd3, 2'd1, 2'd0, 2'd2}, // R6 inval rank 0
        {4'd3,  2'd1, 4'd5,  2'd2, 2'd2, 2'd3, 2'd1, 2'd0}, // R3 hit rank 3
        {4'd9,  2'd0, 4'd9,  2'd0, 2'd0, 2'd1, 2'd2, 2'd3}, // R9 other set untouched
        {4'd3,  2'd1, 4'd9,  2'd3, 2'd3, 2'd0, 2'd1, 2'd2}, // R3 on set 9
        {4'd9,  2'd0, 4'd5,  2'd0, 2'd2, 2'd3, 2'd1, 2'd0}, // R9 set 5 kept
        {4'd3,  2'd1, 4'd2,  2'd1, 2'd1, 2'd0, 2'd2, 2'd3}, // R3 set 2 to 1,0,2,3
        {4'd6,  2'd3, 4'd2,  2'd0, 2'd1, 2'd2, 2'd3, 2'd0}, // R6 stated example
        {4'd5,  2'd2, 4'd12, 2'd1, 2'd3, 2'd0, 2'd1, 2'd2}  // R5 fill on fresh set
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic perm_ok(input logic [7:0] o);
        logic [3:0] m = 4'b0;
        for (int i = 0; i < 4; i++) m[o[2*i +: 2]] = 1'b1;
        return m == 4'hF;
    endfunction

    task automatic apply(input logic [1:0] op, input logic [IDX_W-1:0] s, input logic [1:0] w);
        @(negedge clk);
        op_i = op; set_i = s; way_i = w;
        @(posedge clk);
        #2;
        op_i = 2'd0;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: every set starts at 0,1,2,3 with victim 3
        for (int s = 0; s < (1 << IDX_W); s++) begin
            set_i = IDX_W'(s);
            #1;
            check("R1 reset order", order_o, 8'hE4);
            check("R1 reset victim", {6'd0, victim_o}, 8'd3);
        end

        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] expo;
            expo = {VEC[k][1:0], VEC[k][3:2], VEC[k][5:4], VEC[k][7:6]};
            apply(VEC[k][15:14], VEC[k][13:10], VEC[k][9:8]);
            checks++;
            if (order_o !== expo) begin
                errors++;
                $display("FAIL R%0d step %0d actual %h expected %h",
                         VEC[k][21:18], k, order_o, expo);
            end
            check("R2 permutation", {7'd0, perm_ok(order_o)}, 8'd1);
        end

        // R8: read-out follows set_i within the cycle, victim is the back rank
        @(negedge clk);
        set_i = 4'd5; #1;
        check("R8 victim set 5", {6'd0, victim_o}, 8'd0);
        set_i = 4'd9; #1;
        check("R8 victim set 9", {6'd0, victim_o}, 8'd2);
        set_i = 4'd2; #1;
        check("R8 order set 2", order_o, {2'd0, 2'd3, 2'd2, 2'd1});

        // R8: update only visible after the edge
        @(negedge clk);
        op_i = 2'd3; set_i = 4'd7; way_i = 2'd0; #1;
        check("R8 before edge", order_o, 8'hE4);
        @(posedge clk); #1;
        op_i = 2'd0; #1;
        check("R8 after edge", order_o, {2'd0, 2'd3, 2'd2, 2'd1});

        // R1: a later reset restores a used set
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        set_i = 4'd5; #1;
        check("R1 re-reset", order_o, 8'hE4);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule